// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer with a three-register memory-mapped interface. A counter advances once per slow tick pulse while counting is enabled. When it reaches the programmed limit, the block raises a reset request. Software keeps the system alive by writing a refresh key to the command register. The refresh key is either one 32-bit word or two 16-bit halves in a fixed order; a control bit selects which form is expected.

The control and limit registers are normally write-protected. An unlock key, in the same two forms, opens a short reconfiguration window. That window accepts exactly one configuration write. It also closes by itself after a fixed number of bus clocks. If software applies a configuration with the "allow reconfiguration" bit cleared, the block refuses every later unlock until reset.

The reset request is registered. It stays high for a fixed number of tick periods, after which the counter restarts from zero. Reading the command register returns the current count.

Top module: `keywdt_top`

## Requirements
- R1: After reset, the control register (offset 0x0) reads 0x0000_0120, meaning clock select 1 and the reconfiguration-allow bit set. The count reads 0, the limit register (offset 0x8) reads all ones, and rst_req is low.
- R2: When control bit 13 is 1, a write of 0xB480A602 to offset 0x4 clears the count. Any other word written there leaves the count unchanged, including the two 16-bit halves written separately.
- R3: When control bit 13 is 0, a write of 0xA602 followed by a write of 0xB480 (low 16 bits compared) clears the count. The second half on its own has no effect, and neither does the reverse order. A first half followed by any other value before the second half also has no effect.
- R4: An unlock key sets control bit 11 from the cycle after it is written. In 32-bit mode the key is 0xD928C520. In 16-bit mode it is 0xC520 followed by 0xD928. In 32-bit mode, writing the 16-bit halves does not unlock.
- R5: While bit 11 is clear, writes to offset 0x0 and offset 0x8 are ignored.
- R6: The first write to offset 0x0 or 0x8 after an unlock is applied. That write clears bit 11 and sets bit 10. Bit 10 stays set until the next unlock, and any further configuration write is ignored.
- R7: The unlock window closes by itself WIN_CYC bus clocks after the unlock. After that, configuration writes are ignored.
- R8: If bit 5 is 0 once a configuration write is applied, every later unlock is refused until reset. A reset makes unlocking possible again.
- R9: The count rises by one per tick pulse, but only while bit 7 is 1 and bits 9:8 equal 1. In every other setting, ticks leave the count unchanged.
- R10: Suppose the count starts from zero (after reset or a refresh) and the limit is L. Then rst_req rises at the L-th counted tick, and the count then reads L. This includes L = 1000.
- R11: rst_req stays high for RST_HOLD tick pulses. On the last of these it falls and the count returns to 0. Refresh keys written while rst_req is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-clock pulse per slow counter period |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 4 | Byte offset: 0x0 control, 0x4 command/count, 0x8 limit |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| rst_req | output | 1 | Registered reset request |

## Verification
The bench builds the block with TO_W = 17, WIN_CYC = 16 and RST_HOLD = 4. A short window brings expiry of the unlock window within a few bus writes. A hold of four ticks lets the whole assert-and-release cycle of the reset request be counted edge by edge. The 17-bit limit still holds the full 128-second value, and one run uses a limit of 1000 ticks to exercise a realistic one-second timeout.

// File: rtl/keywdt_pkg.sv
// Shared constants and types for the key-protected watchdog.
// Assumes byte offsets on a 4-bit address and 32-bit data.
package keywdt_pkg;
    localparam logic [3:0] OFS_CTRL  = 4'h0;
    localparam logic [3:0] OFS_CMD   = 4'h4;
    localparam logic [3:0] OFS_LIMIT = 4'h8;

    localparam int BIT_CMD32  = 13;
    localparam int BIT_OPEN   = 11;
    localparam int BIT_APPLY  = 10;
    localparam int BIT_CSEL_H = 9;
    localparam int BIT_CSEL_L = 8;
    localparam int BIT_RUN    = 7;
    localparam int BIT_ALLOW  = 5;

    localparam logic [1:0] CSEL_TICK = 2'b01;

    localparam int NKEYS   = 2;
    localparam int KEY_REF = 0;
    localparam int KEY_UNL = 1;
    localparam logic [NKEYS-1:0][31:0] KEY_WORDS = {32'hD928C520, 32'hB480A602};

    typedef struct packed {
        logic       cmd32;
        logic [1:0] csel;
        logic       run;
        logic       allow;
    } ctrl_t;
endpackage

// File: rtl/keywdt_keydec.sv
// Key sequence decoder: one detector per key word.
// In 32-bit mode a key must arrive as a single whole word.
// In 16-bit mode it must arrive as its low half, then its high half, on consecutive command writes.
// Assumes wr_cmd is a single-cycle write strobe; hits are combinational with the write.
module keywdt_keydec
    import keywdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cmd,
    input  logic [31:0]      wdata,
    input  logic             mode32,
    output logic [NKEYS-1:0] hit
);
    for (genvar k = 0; k < NKEYS; k++) begin : g_key
        logic half_seen;

        // Remember whether the last command write was this key's first half.
        always_ff @(posedge clk) begin
            if (!rst_n)
                half_seen <= 1'b0;
            else if (wr_cmd)
                half_seen <= !mode32 && (wdata[15:0] == KEY_WORDS[k][15:0]);
        end

        // Recognise the whole key, or the second half after a pending first half.
        always_comb begin
            if (!wr_cmd)
                hit[k] = 1'b0;
            else if (mode32)
                hit[k] = (wdata == KEY_WORDS[k]);
            else
                hit[k] = half_seen && (wdata[15:0] == KEY_WORDS[k][31:16]);
        end
    end
endmodule

// File: rtl/keywdt_cfg.sv
// Configuration registers with the unlock window and permanent lockout.
// One configuration write is accepted per unlock, and the window lapses after WIN_CYC clocks.
// Assumes at most one of unlock_hit, wr_ctrl and wr_limit is active per cycle.
module keywdt_cfg
    import keywdt_pkg::*;
#(
    parameter int TO_W    = 17,
    parameter int WIN_CYC = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            unlock_hit,
    input  logic            wr_ctrl,
    input  logic            wr_limit,
    input  ctrl_t           ctrl_wdata,
    input  logic [TO_W-1:0] limit_wdata,
    output ctrl_t           ctrl,
    output logic [TO_W-1:0] limit,
    output logic            unlocked,
    output logic            applied,
    output logic            lockout
);
    localparam int WIN_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;

    logic [WIN_W-1:0] win_left;
    logic             accept;
    logic             allow_after;

    assign accept      = unlocked && (wr_ctrl || wr_limit);
    assign allow_after = wr_ctrl ? ctrl_wdata.allow : ctrl.allow;

    // Window state: open on a key, close on the first accepted write or on timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
            win_left <= '0;
            applied  <= 1'b0;
            lockout  <= 1'b0;
        end else if (unlock_hit && !lockout) begin
            unlocked <= 1'b1;
            win_left <= WIN_W'(WIN_CYC - 1);
            applied  <= 1'b0;
        end else if (accept) begin
            unlocked <= 1'b0;
            applied  <= 1'b1;
            lockout  <= lockout || !allow_after;
        end else if (unlocked) begin
            if (win_left == '0)
                unlocked <= 1'b0;
            else
                win_left <= win_left - 1'b1;
        end
    end

    // Register contents, updated only by an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= '{cmd32: 1'b0, csel: CSEL_TICK, run: 1'b0, allow: 1'b1};
            limit <= '1;
        end else if (accept) begin
            if (wr_ctrl)
                ctrl <= ctrl_wdata;
            if (wr_limit)
                limit <= limit_wdata;
        end
    end
endmodule

// File: rtl/keywdt_core.sv
// Watchdog counter and reset request.
// Counts tick pulses while enabled and raises a registered request when the limit is reached.
// The request is held for RST_HOLD ticks, then the counter restarts from zero.
// Assumes tick is a single-cycle pulse.
module keywdt_core #(
    parameter int TO_W     = 17,
    parameter int RST_HOLD = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            count_en,
    input  logic            refresh,
    input  logic [TO_W-1:0] limit,
    output logic [TO_W-1:0] cnt,
    output logic            rst_req
);
    localparam int HOLD_W = (RST_HOLD > 1) ? $clog2(RST_HOLD) : 1;

    logic [HOLD_W-1:0] hold;
    logic [TO_W-1:0]   cnt_next;

    assign cnt_next = cnt + 1'b1;

    // Counter, hold timer and request flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            hold    <= '0;
            rst_req <= 1'b0;
        end else if (rst_req) begin
            if (tick) begin
                if (hold == HOLD_W'(RST_HOLD - 1)) begin
                    rst_req <= 1'b0;
                    hold    <= '0;
                    cnt     <= '0;
                end else begin
                    hold <= hold + 1'b1;
                end
            end
        end else if (refresh) begin
            cnt <= '0;
        end else if (count_en && tick) begin
            cnt <= cnt_next;
            if (cnt_next >= limit)
                rst_req <= 1'b1;
        end
    end
endmodule

// File: rtl/keywdt_top.sv
// Key-protected watchdog top: register decode, read mux, and the three sub-blocks.
// Assumes single-cycle bus writes and a combinational read on bus_addr; TO_W is at most 32.
module keywdt_top
    import keywdt_pkg::*;
#(
    parameter int TO_W     = 17,
    parameter int WIN_CYC  = 128,
    parameter int RST_HOLD = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        rst_req
);
    logic             wr_any, wr_cmd, wr_ctrl, wr_limit, cfg_wr_any;
    logic [NKEYS-1:0] key_hit;
    logic             refresh_hit, unlock_hit;
    ctrl_t            ctrl, ctrl_wdata;
    logic [TO_W-1:0]  limit, cnt;
    logic             unlocked, applied, lockout, en, count_en;

    assign wr_any     = bus_sel && bus_wr;
    assign wr_cmd     = wr_any && (bus_addr == OFS_CMD);
    assign wr_ctrl    = wr_any && (bus_addr == OFS_CTRL);
    assign wr_limit   = wr_any && (bus_addr == OFS_LIMIT);
    assign cfg_wr_any = wr_ctrl || wr_limit;

    assign ctrl_wdata = '{cmd32: bus_wdata[BIT_CMD32],
                          csel:  bus_wdata[BIT_CSEL_H:BIT_CSEL_L],
                          run:   bus_wdata[BIT_RUN],
                          allow: bus_wdata[BIT_ALLOW]};

    assign refresh_hit = key_hit[KEY_REF];
    assign unlock_hit  = key_hit[KEY_UNL];
    assign en          = ctrl.run;
    assign count_en    = en && (ctrl.csel == CSEL_TICK);

    keywdt_keydec u_keydec (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_cmd (wr_cmd),
        .wdata  (bus_wdata),
        .mode32 (ctrl.cmd32),
        .hit    (key_hit)
    );

    keywdt_cfg #(.TO_W(TO_W), .WIN_CYC(WIN_CYC)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .unlock_hit  (unlock_hit),
        .wr_ctrl     (wr_ctrl),
        .wr_limit    (wr_limit),
        .ctrl_wdata  (ctrl_wdata),
        .limit_wdata (bus_wdata[TO_W-1:0]),
        .ctrl        (ctrl),
        .limit       (limit),
        .unlocked    (unlocked),
        .applied     (applied),
        .lockout     (lockout)
    );

    keywdt_core #(.TO_W(TO_W), .RST_HOLD(RST_HOLD)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .count_en (count_en),
        .refresh  (refresh_hit),
        .limit    (limit),
        .cnt      (cnt),
        .rst_req  (rst_req)
    );

    // Read mux: status flags merged into the control word.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[BIT_CMD32]             = ctrl.cmd32;
                bus_rdata[BIT_OPEN]              = unlocked;
                bus_rdata[BIT_APPLY]             = applied;
                bus_rdata[BIT_CSEL_H:BIT_CSEL_L] = ctrl.csel;
                bus_rdata[BIT_RUN]               = ctrl.run;
                bus_rdata[BIT_ALLOW]             = ctrl.allow;
            end
            OFS_CMD:   bus_rdata = 32'(cnt);
            OFS_LIMIT: bus_rdata = 32'(limit);
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/keywdt_chk.sv
// Checker for keywdt_top, attached by bind. It observes ports and sub-block boundaries only.
module keywdt_chk #(
    parameter int TO_W     = 17,
    parameter int WIN_CYC  = 128,
    parameter int RST_HOLD = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick,
    input logic            rst_req,
    input logic            unlocked,
    input logic            lockout,
    input logic            unlock_hit,
    input logic            refresh_hit,
    input logic            cfg_wr,
    input logic            en,
    input logic [TO_W-1:0] cnt
);
    int unsigned ticks_high;
    int unsigned open_age;

    // Count tick pulses seen while the request is high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ticks_high <= 0;
        else if (!rst_req)
            ticks_high <= 0;
        else if (tick)
            ticks_high <= ticks_high + 1;
    end

    // Age of the current unlock window in clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            open_age <= 0;
        else if (unlock_hit && !lockout)
            open_age <= 1;
        else if (unlocked)
            open_age <= open_age + 1;
        else
            open_age <= 0;
    end

    AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req && tick && ticks_high == RST_HOLD - 1 |=> !rst_req); // R11
    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req && ticks_high < RST_HOLD - 1 |=> rst_req); // R11
    AST_WINDOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked |-> open_age <= WIN_CYC); // R7
    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked && cfg_wr |=> !unlocked); // R6
    AST_LOCKOUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> !$rose(unlocked)); // R8
    AST_REFRESH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_hit && !rst_req |=> cnt == '0); // R2
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !en && !rst_req |=> $stable(cnt) || cnt == '0); // R9
endmodule

bind keywdt_top keywdt_chk #(.TO_W(TO_W), .WIN_CYC(WIN_CYC), .RST_HOLD(RST_HOLD)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .rst_req     (rst_req),
    .unlocked    (unlocked),
    .lockout     (lockout),
    .unlock_hit  (unlock_hit),
    .refresh_hit (refresh_hit),
    .cfg_wr      (cfg_wr_any),
    .en          (en),
    .cnt         (cnt)
);

// File: tb/sim_keywdt_top.sv
// Directed bench for keywdt_top: one task per scenario, each checking its own results.
module sim_keywdt_top;
    localparam int CLK_PERIOD = 10;
    localparam int TO_W       = 17;
    localparam int WIN_CYC    = 16;
    localparam int RST_HOLD   = 4;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    keywdt_top #(.TO_W(TO_W), .WIN_CYC(WIN_CYC), .RST_HOLD(RST_HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic unlock16(); wr(4'h4, 32'h0000C520); wr(4'h4, 32'h0000D928); endtask
    task automatic unlock32(); wr(4'h4, 32'hD928C520); endtask
    task automatic refresh16(); wr(4'h4, 32'h0000A602); wr(4'h4, 32'h0000B480); endtask
    task automatic refresh32(); wr(4'h4, 32'hB480A602); endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(4'h0, d); check("R1 ctrl", d, 32'h0000_0120);
        rd(4'h4, d); check("R1 count", d, 32'h0);
        rd(4'h8, d); check("R1 limit", d, 32'h0001_FFFF);
        check("R1 rst_req", 32'(rst_req), 32'h0);
    endtask

    task automatic t_locked();
        logic [31:0] d;
        wr(4'h0, 32'h0000_21A0);
        rd(4'h0, d); check("R5 ctrl locked", d, 32'h0000_0120);
        wr(4'h8, 32'd5);
        rd(4'h8, d); check("R5 limit locked", d, 32'h0001_FFFF);
    endtask

    task automatic t_one_write();
        logic [31:0] d;
        unlock16();
        rd(4'h0, d); check("R4 unlock16", d, 32'h0000_0920);
        wr(4'h8, 32'd6);
        rd(4'h8, d); check("R6 limit applied", d, 32'd6);
        rd(4'h0, d); check("R6 closed and applied", d, 32'h0000_0520);
        wr(4'h0, 32'h0000_01A0);
        rd(4'h0, d); check("R6 second write ignored", d, 32'h0000_0520);
    endtask

    task automatic t_count();
        logic [31:0] d;
        unlock16();
        wr(4'h0, 32'h0000_01A0);
        rd(4'h0, d); check("R9 enabled ctrl", d, 32'h0000_05A0);
        ticks(3);
        rd(4'h4, d); check("R9 counts ticks", d, 32'd3);
    endtask

    task automatic t_refresh16();
        logic [31:0] d;
        wr(4'h4, 32'h0000B480);
        rd(4'h4, d); check("R3 lone second half", d, 32'd3);
        wr(4'h4, 32'h0000B480); wr(4'h4, 32'h0000A602); wr(4'h4, 32'h00001234);
        rd(4'h4, d); check("R3 reverse order", d, 32'd3);
        wr(4'h4, 32'h0000A602); wr(4'h4, 32'h00000000); wr(4'h4, 32'h0000B480);
        rd(4'h4, d); check("R3 interrupted", d, 32'd3);
        refresh16();
        rd(4'h4, d); check("R3 refresh16", d, 32'd0);
    endtask

    task automatic t_timeout();
        logic [31:0] d;
        ticks(5);
        rd(4'h4, d); check("R10 count before limit", d, 32'd5);
        check("R10 no request early", 32'(rst_req), 32'h0);
        ticks(1);
        check("R10 request at limit", 32'(rst_req), 32'h1);
        rd(4'h4, d); check("R10 count at limit", d, 32'd6);
    endtask

    task automatic t_hold();
        logic [31:0] d;
        refresh16();
        rd(4'h4, d); check("R11 refresh ignored in hold", d, 32'd6);
        ticks(RST_HOLD - 1);
        check("R11 still held", 32'(rst_req), 32'h1);
        ticks(1);
        check("R11 released", 32'(rst_req), 32'h0);
        rd(4'h4, d); check("R11 count cleared", d, 32'd0);
        ticks(1);
        rd(4'h4, d); check("R11 counting resumes", d, 32'd1);
    endtask

    task automatic t_gating();
        logic [31:0] d;
        unlock16();
        wr(4'h0, 32'h0000_02A0);
        rd(4'h0, d); check("R9 other clock select", d, 32'h0000_06A0);
        ticks(2);
        rd(4'h4, d); check("R9 no count other select", d, 32'd1);
        unlock16();
        wr(4'h0, 32'h0000_0120);
        ticks(2);
        rd(4'h4, d); check("R9 no count disabled", d, 32'd1);
    endtask

    task automatic t_mode32();
        logic [31:0] d;
        unlock16();
        wr(4'h0, 32'h0000_21A0);
        rd(4'h0, d); check("R2 mode32 ctrl", d, 32'h0000_25A0);
        ticks(2);
        refresh16();
        rd(4'h4, d); check("R2 halves ignored", d, 32'd3);
        refresh32();
        rd(4'h4, d); check("R2 refresh32", d, 32'd0);
        unlock16();
        rd(4'h0, d); check("R4 halves no unlock", d, 32'h0000_25A0);
        unlock32();
        rd(4'h0, d); check("R4 unlock32", d, 32'h0000_29A0);
    endtask

    task automatic t_window();
        logic [31:0] d;
        repeat (WIN_CYC + 2) @(negedge clk);
        rd(4'h0, d); check("R7 window lapsed", d, 32'h0000_21A0);
        wr(4'h8, 32'd3);
        rd(4'h8, d); check("R7 write after lapse", d, 32'd6);
    endtask

    task automatic t_long();
        logic [31:0] d;
        unlock32();
        wr(4'h8, 32'd1000);
        refresh32();
        ticks(999);
        rd(4'h4, d); check("R10 long count", d, 32'd999);
        check("R10 long no request", 32'(rst_req), 32'h0);
        ticks(1);
        check("R10 long request", 32'(rst_req), 32'h1);
        ticks(RST_HOLD);
        check("R11 long release", 32'(rst_req), 32'h0);
    endtask

    task automatic t_lockout();
        logic [31:0] d;
        unlock32();
        wr(4'h0, 32'h0000_2180);
        rd(4'h0, d); check("R8 applied no allow", d, 32'h0000_2580);
        unlock32();
        rd(4'h0, d); check("R8 unlock refused", d, 32'h0000_2580);
        wr(4'h8, 32'd7);
        rd(4'h8, d); check("R8 limit kept", d, 32'd1000);
        do_reset();
        unlock16();
        rd(4'h0, d); check("R8 unlock after reset", d, 32'h0000_0920);
    endtask

    initial begin
        t_reset();
        t_locked();
        t_one_write();
        t_count();
        t_refresh16();
        t_timeout();
        t_hold();
        t_gating();
        t_mode32();
        t_window();
        t_long();
        t_lockout();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule